// File: doc/BRIEF.md
# Scan Pacer and Burst Conversion Timer

This block produces the start-of-conversion strobe for a sampling front end. Every clock cycle is one tick of the fixed conversion time base. A wide pacer down-counter sets the period between scans. A narrow burst down-counter spaces the individual conversions inside one scan. Both counters are loaded with the division ratio minus one. A ratio below two is raised to two.

Three selects route the timing. The first picks what starts the pacer: a software pulse or the external trigger. The second picks what launches a burst: a pacer tick, the external trigger, or nothing. The third picks what fires a conversion: a software pulse, the pacer, the burst clock or the external trigger. In single-channel use the pacer drives conversions directly. In multi-channel use each pacer tick starts a burst of `scanLen` conversions. A software stop halts everything at once.

Top module: `conv_pacer_burst`

## Requirements
- R1: While reset is held and after it is released, `convStrobe` is 0, and the pacer and burst stay idle until they are started.
- R2: With `convSel` = 0, a `swConvert` pulse gives one `convStrobe` on the next cycle. With `convSel` = 3, an `extTrig` pulse does the same.
- R3: With `convSel` = 1 and a pacer value L, the first strobe comes L+1 cycles after the start pulse is sampled. Further strobes follow every L+1 cycles.
- R4: `pacerSrc` = 0 starts the pacer on `swStart`, and `pacerSrc` = 1 starts it on `extTrig`. The input that is not selected does nothing. A start that arrives while the pacer is running is ignored.
- R5: A pacer or burst value of 0 is treated as 1, so the shortest period is 2 cycles.
- R6: A new division value written while a counter runs is used only from that counter's next terminal count.
- R7: A `swStop` pulse stops the pacer and drops any burst in progress. No pacer or burst strobe appears from the cycle in which the stop is sampled. A stop wins over a start sampled in the same cycle.
- R8: With `burstSrc` = 1 and `convSel` = 2, each pacer tick starts a burst. The first strobe comes one cycle after the burst starts. The burst gives exactly `scanLen` strobes, spaced by the burst period B+1, and then goes idle.
- R9: `burstSrc` = 2 starts a burst on `extTrig`. `burstSrc` values 0 and 3 never start a burst.
- R10: A burst start that arrives while a burst is active is ignored. A `scanLen` of 0 never starts a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion time base; one cycle is one tick |
| rstN | input | 1 | Asynchronous active-low reset |
| convSel | input | 2 | Conversion source: 0 software, 1 pacer, 2 burst, 3 external |
| pacerSrc | input | 1 | Pacer start source: 0 software, 1 external |
| burstSrc | input | 2 | Burst start source: 1 pacer tick, 2 external, 0 or 3 off |
| pacerDiv | input | 24 | Pacer ratio minus one |
| burstDiv | input | 10 | Burst ratio minus one |
| scanLen | input | 8 | Conversions per burst |
| swStart | input | 1 | Software pacer start pulse |
| swStop | input | 1 | Software stop pulse |
| swConvert | input | 1 | Software conversion pulse |
| extTrig | input | 1 | External trigger, one pulse per event |
| convStrobe | output | 1 | One-cycle conversion strobe |

## Verification
Every strobe is registered once after the event that causes it:
- A direct software or external source appears one cycle after its pulse.
- A pacer tick appears L+1 cycles after the start is sampled.
- A burst strobe appears one cycle after the burst launches, and every B+1 cycles after that.

The bench holds a behavioural model that steps at each rising edge from the same sampled inputs. The model's expected strobe is compared with `convStrobe` at every falling edge, half a cycle after the register updates. Directed checks also count strobes over windows whose lengths are worked out from those latencies. For example, 8 strobes are expected in 90 cycles for a 30-cycle scan of 4 conversions.

// File: rtl/conv_timer_pkg.sv
package conv_timer_pkg;

  // Conversion source codes
  localparam logic [1:0] CONV_SOFT  = 2'd0;
  localparam logic [1:0] CONV_PACER = 2'd1;
  localparam logic [1:0] CONV_BURST = 2'd2;
  localparam logic [1:0] CONV_EXT   = 2'd3;

  // Burst launch codes
  localparam logic [1:0] BLAUNCH_PACER = 2'd1;
  localparam logic [1:0] BLAUNCH_EXT   = 2'd2;

  // Pacer start codes
  localparam logic PSTART_SOFT = 1'b0;
  localparam logic PSTART_EXT  = 1'b1;

  // Strobes sent from control to datapath
  typedef struct packed {
    logic pacerLoad;
    logic pacerDec;
    logic burstClr;
    logic burstLoad;
    logic burstDec;
    logic convFire;
  } ctl_strobe_t;

endpackage

// File: rtl/tick_down_counter.sv
module tick_down_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clr,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] loadVal,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (load)  cnt <= loadVal;
    else if (dec)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/conv_timer_dp.sv
module conv_timer_dp
  import conv_timer_pkg::*;
#(
  parameter int PACER_W = 24,
  parameter int BURST_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctl_strobe_t        stb,
  input  logic [PACER_W-1:0] pacerDiv,
  input  logic [BURST_W-1:0] burstDiv,
  output logic               pacerZero,
  output logic               burstZero,
  output logic               convStrobe
);
  localparam logic [PACER_W-1:0] PACER_MIN = PACER_W'(1);
  localparam logic [BURST_W-1:0] BURST_MIN = BURST_W'(1);

  // Raise a load value of 0 to 1, so the ratio is never below 2
  logic [PACER_W-1:0] pacerEff;
  logic [BURST_W-1:0] burstEff;
  assign pacerEff = (pacerDiv < PACER_MIN) ? PACER_MIN : pacerDiv;
  assign burstEff = (burstDiv < BURST_MIN) ? BURST_MIN : burstDiv;

  tick_down_counter #(.W(PACER_W)) u_pacerCnt (
    .clk(clk), .rstN(rstN), .clr(1'b0),
    .load(stb.pacerLoad), .dec(stb.pacerDec),
    .loadVal(pacerEff), .zero(pacerZero)
  );

  tick_down_counter #(.W(BURST_W)) u_burstCnt (
    .clk(clk), .rstN(rstN), .clr(stb.burstClr),
    .load(stb.burstLoad), .dec(stb.burstDec),
    .loadVal(burstEff), .zero(burstZero)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) convStrobe <= 1'b0;
    else       convStrobe <= stb.convFire;
  end
endmodule

// File: rtl/conv_timer_ctl.sv
module conv_timer_ctl
  import conv_timer_pkg::*;
#(
  parameter int SCAN_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        convSel,
  input  logic              pacerSrc,
  input  logic [1:0]        burstSrc,
  input  logic [SCAN_W-1:0] scanLen,
  input  logic              swStart,
  input  logic              swStop,
  input  logic              swConvert,
  input  logic              extTrig,
  input  logic              pacerZero,
  input  logic              burstZero,
  output ctl_strobe_t       stb
);
  localparam logic [SCAN_W-1:0] ONE_LEFT = SCAN_W'(1);

  logic              pacerRun;
  logic              burstAct;
  logic [SCAN_W-1:0] remaining;

  logic pacerTick, burstTick, pacerStartEv, burstStartEv, lastConv;

  always_comb begin
    pacerTick    = pacerRun && pacerZero && !swStop;
    burstTick    = burstAct && burstZero && !swStop;
    pacerStartEv = !pacerRun && !swStop &&
                   ((pacerSrc == PSTART_SOFT && swStart) ||
                    (pacerSrc == PSTART_EXT  && extTrig));
    burstStartEv = !burstAct && !swStop && (scanLen != '0) &&
                   ((burstSrc == BLAUNCH_PACER && pacerTick) ||
                    (burstSrc == BLAUNCH_EXT   && extTrig));
    lastConv     = (remaining == ONE_LEFT);

    stb.pacerLoad = pacerStartEv || pacerTick;
    stb.pacerDec  = pacerRun && !pacerZero;
    stb.burstClr  = burstStartEv;
    stb.burstLoad = burstTick && !lastConv;
    stb.burstDec  = burstAct && !burstZero;
    unique case (convSel)
      CONV_SOFT:  stb.convFire = swConvert;
      CONV_PACER: stb.convFire = pacerTick;
      CONV_BURST: stb.convFire = burstTick;
      default:    stb.convFire = extTrig;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pacerRun  <= 1'b0;
      burstAct  <= 1'b0;
      remaining <= '0;
    end else if (swStop) begin
      pacerRun  <= 1'b0;
      burstAct  <= 1'b0;
    end else begin
      if (pacerStartEv) pacerRun <= 1'b1;
      if (burstStartEv) begin
        burstAct  <= 1'b1;
        remaining <= scanLen;
      end else if (burstTick) begin
        if (lastConv) burstAct <= 1'b0;
        remaining <= remaining - 1'b1;
      end
    end
  end
endmodule

// File: rtl/conv_pacer_burst.sv
module conv_pacer_burst
  import conv_timer_pkg::*;
#(
  parameter int PACER_W = 24,
  parameter int BURST_W = 10,
  parameter int SCAN_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         convSel,
  input  logic               pacerSrc,
  input  logic [1:0]         burstSrc,
  input  logic [PACER_W-1:0] pacerDiv,
  input  logic [BURST_W-1:0] burstDiv,
  input  logic [SCAN_W-1:0]  scanLen,
  input  logic               swStart,
  input  logic               swStop,
  input  logic               swConvert,
  input  logic               extTrig,
  output logic               convStrobe
);
  ctl_strobe_t stb;
  logic pacerZero, burstZero;

  conv_timer_ctl #(.SCAN_W(SCAN_W)) u_ctl (
    .clk(clk), .rstN(rstN), .convSel(convSel), .pacerSrc(pacerSrc),
    .burstSrc(burstSrc), .scanLen(scanLen), .swStart(swStart),
    .swStop(swStop), .swConvert(swConvert), .extTrig(extTrig),
    .pacerZero(pacerZero), .burstZero(burstZero), .stb(stb)
  );

  conv_timer_dp #(.PACER_W(PACER_W), .BURST_W(BURST_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pacerDiv(pacerDiv),
    .burstDiv(burstDiv), .pacerZero(pacerZero), .burstZero(burstZero),
    .convStrobe(convStrobe)
  );
endmodule

// File: rtl/conv_timer_chk.sv
module conv_timer_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] convSel,
  input logic       swStop,
  input logic       swConvert,
  input logic       extTrig,
  input logic       convStrobe
);
  // R2
  soft_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convSel == 2'd0) |=> (convStrobe == $past(swConvert)));

  // R2
  ext_conv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convSel == 2'd3) |=> (convStrobe == $past(extTrig)));

  // R7
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swStop && (convSel == 2'd1 || convSel == 2'd2)) |=> !convStrobe);

  // R5
  pacer_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convStrobe && convSel == 2'd1 && $past(convSel) == 2'd1) |=> !convStrobe);

  // R1
  reset_low_chk: assert property (@(posedge clk)
    !rstN |=> !convStrobe);
endmodule

bind conv_pacer_burst conv_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .convSel(convSel), .swStop(swStop),
  .swConvert(swConvert), .extTrig(extTrig), .convStrobe(convStrobe)
);

// File: tb/conv_pacer_burst_test.sv
module conv_pacer_burst_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  convSel = 2'd0;
  logic        pacerSrc = 1'b0;
  logic [1:0]  burstSrc = 2'd0;
  logic [23:0] pacerDiv = 24'd4;
  logic [9:0]  burstDiv = 10'd3;
  logic [7:0]  scanLen = 8'd0;
  logic        swStart = 1'b0, swStop = 1'b0, swConvert = 1'b0, extTrig = 1'b0;
  logic        convStrobe;

  int total = 0, bad = 0;
  string curReq = "R1";
  bit finished = 0;

  always #5 clk = ~clk;

  conv_pacer_burst uut (
    .clk(clk), .rstN(rstN), .convSel(convSel), .pacerSrc(pacerSrc),
    .burstSrc(burstSrc), .pacerDiv(pacerDiv), .burstDiv(burstDiv),
    .scanLen(scanLen), .swStart(swStart), .swStop(swStop),
    .swConvert(swConvert), .extTrig(extTrig), .convStrobe(convStrobe)
  );

  // Behavioural reference: a cycle countdown for each timer
  int  pWait, bWait, bLeft;
  bit  pOn, bOn, expStrobe;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pOn = 0; bOn = 0; pWait = 0; bWait = 0; bLeft = 0; expStrobe = 0;
    end else begin
      int pPer, bPer;
      bit pFire, bFire, pGo, bGo;
      pPer  = (pacerDiv == 0) ? 1 : int'(pacerDiv);
      bPer  = (burstDiv == 0) ? 1 : int'(burstDiv);
      pFire = pOn && pWait == 0 && !swStop;
      bFire = bOn && bWait == 0 && !swStop;
      pGo   = !pOn && !swStop && (pacerSrc ? extTrig : swStart);
      bGo   = !bOn && !swStop && scanLen != 0 &&
              ((burstSrc == 2'd1 && pFire) || (burstSrc == 2'd2 && extTrig));
      case (convSel)
        2'd0: expStrobe = swConvert;
        2'd1: expStrobe = pFire;
        2'd2: expStrobe = bFire;
        default: expStrobe = extTrig;
      endcase
      if (swStop) begin
        pOn = 0; bOn = 0;
      end else begin
        if (pGo) begin pOn = 1; pWait = pPer; end
        else if (pOn) pWait = (pWait == 0) ? pPer : pWait - 1;
        if (bGo) begin bOn = 1; bWait = 0; bLeft = scanLen; end
        else if (bOn) begin
          if (bWait == 0) begin
            bLeft--;
            if (bLeft == 0) bOn = 0; else bWait = bPer;
          end else bWait--;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      total++;
      if (convStrobe !== expStrobe) begin
        bad++;
        $display("FAIL %s per-cycle strobe actual=%0b expected=%0b at %0t",
                 curReq, convStrobe, expStrobe, $time);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // which: 0 start, 1 stop, 2 convert, 3 external
  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: swStart = 1; 1: swStop = 1; 2: swConvert = 1; default: extTrig = 1;
    endcase
    @(negedge clk);
    swStart = 0; swStop = 0; swConvert = 0; extTrig = 0;
  endtask

  task automatic countStrobes(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (convStrobe) c++;
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired in %s", curReq);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    check("R1 strobe in reset", convStrobe, 0);
    rstN = 1;
    countStrobes(10, c); check("R1 idle after reset", c, 0);

    curReq = "R2";
    convSel = 2'd0;
    @(negedge clk); swConvert = 1;
    @(negedge clk); swConvert = 0;
    check("R2 soft strobe next cycle", convStrobe, 1);
    @(negedge clk); check("R2 soft strobe one cycle", convStrobe, 0);
    convSel = 2'd3;
    @(negedge clk); extTrig = 1;
    @(negedge clk); extTrig = 0;
    check("R2 ext strobe next cycle", convStrobe, 1);

    curReq = "R3";
    convSel = 2'd1; pacerSrc = 0; pacerDiv = 24'd4;
    pulse(0);
    countStrobes(50, c); check("R3 pacer period 5 over 50", c, 10);
    curReq = "R4";
    pulse(0);
    countStrobes(20, c); check("R4 restart while running ignored", c, 4);

    curReq = "R7";
    pulse(1);
    countStrobes(20, c); check("R7 stopped pacer silent", c, 0);

    curReq = "R5";
    pacerDiv = 24'd0;
    pulse(0);
    countStrobes(20, c); check("R5 load 0 gives period 2", c, 10);
    pulse(1);

    curReq = "R6";
    pacerDiv = 24'd9;
    pulse(0);
    countStrobes(10, c); check("R6 first period 10", c, 1);
    pacerDiv = 24'd2;
    countStrobes(10, c); check("R6 old period still running", c, 1);
    countStrobes(9, c);  check("R6 new period 3", c, 3);
    pulse(1);

    curReq = "R4";
    pacerSrc = 1; pacerDiv = 24'd4;
    pulse(0);
    countStrobes(10, c); check("R4 soft start ignored in ext mode", c, 0);
    pulse(3);
    countStrobes(50, c); check("R4 ext start", c, 10);
    pulse(1);

    curReq = "R8";
    pacerSrc = 0; convSel = 2'd2; burstSrc = 2'd1;
    pacerDiv = 24'd29; burstDiv = 10'd3; scanLen = 8'd4;
    pulse(0);
    countStrobes(90, c); check("R8 two scans of four", c, 8);
    curReq = "R7";
    pulse(1);
    countStrobes(40, c); check("R7 burst abandoned", c, 0);

    curReq = "R10";
    pacerDiv = 24'd5;
    pulse(0);
    countStrobes(60, c); check("R10 overlapping launches ignored", c, 12);
    pulse(1);
    scanLen = 8'd0;
    pulse(0);
    countStrobes(30, c); check("R10 zero scan length", c, 0);
    pulse(1);

    curReq = "R9";
    burstSrc = 2'd2; scanLen = 8'd3; burstDiv = 10'd1;
    pulse(3);
    countStrobes(10, c); check("R9 ext burst of three", c, 3);
    burstSrc = 2'd0;
    pulse(3);
    countStrobes(10, c); check("R9 burst source off", c, 0);
    burstSrc = 2'd3;
    pulse(3);
    countStrobes(10, c); check("R9 burst source 3 off", c, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule